// File: doc/BRIEF.md
# Sector Hamming Parity Generator

This block sits beside the byte data path of a NAND flash controller and builds single-error-correcting Hamming parity for a 512-byte sector while the bytes stream past. The sector is handled as two separate 256-byte groups. Each group gets sixteen line-parity bits and six column-parity bits. The finished parity comes back as six bytes, packed into three 16-bit words.

Software or a sequencer steers the block with an 8-bit mode code. One code clears all parity state. A second code lets every valid byte update the parity. A third turns the 16-bit read port into a parity readout: each read strobe steps to the next of three words, and after the third it returns to the first. Correcting errors with this parity is left to other logic.

Top module: `sector_ecc_gen`

## Requirements
- R1: Mode code 0xF4 clears both parity groups, the byte count and the readout position. A readout that follows it with no bytes in between returns 0xFFFF in all three words.
- R2: A byte with byteValid high updates parity only while modeCode is 0xB4. Bytes presented under any other mode code leave the parity unchanged.
- R3: Line parity: for each bit k of the byte's 8-bit index within its group, the XOR of all eight data bits goes into LP(2k+1) when index bit k is 1 and into LP(2k) when it is 0. The result is accumulated over the group.
- R4: Column parity: CP0 and CP1 cover the data bits at even and odd positions. CP2 and CP3 cover bits {0,1,4,5} and {2,3,6,7}. CP4 and CP5 cover bits 3:0 and 7:4. The column byte is {CP5..CP0, 2'b11}, with CP5 in bit 7.
- R5: Every parity bit is presented complemented, so a group of 256 bytes of 0xFF reads back as all ones.
- R6: After a clear, bytes 0 to 255 update the first group and bytes 256 to 511 update the second. From byte 512 on, bytes are ignored until the next clear.
- R7: Word 0 is {first LP15..LP8, first LP7..LP0}. Word 1 is {second LP7..LP0, first column byte}. Word 2 is {second column byte, second LP15..LP8}. In each word the upper byte is listed first.
- R8: While modeCode is 0xD4, readData shows the current word, and a readStrobe moves on to the next word in the order 0, 1, 2, 0. Under any other mode readData is zero and the readout position goes back to word 0.
- R9: A readStrobe outside mode 0xD4, including under the clear code, changes neither the parity nor the readout position.
- R10: Driving rstN low has the same effect as a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeCode | input | 8 | Mode code: 0xF4 clear, 0xB4 accumulate, 0xD4 readout |
| byteValid | input | 1 | byteData carries a sector byte this cycle |
| byteData | input | 8 | Sector data byte |
| readStrobe | input | 1 | Advance to the next result word |
| readData | output | 16 | Current result word; zero outside readout mode |

## Verification
Accumulation and readout are both driven by per-cycle strobes, so a byte strobe and a read strobe can arrive in the same cycle. The bench holds readStrobe high on every byte of some sectors fed under 0xB4. It then checks that the readout still starts at word 0 and that all three words match the reference model. In the other direction, it pulses byteValid with nonzero data while in readout mode, leaves readout, comes back, and expects the same three words as before.

// File: rtl/sector_ecc_pkg.sv
package sector_ecc_pkg;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 8;
  localparam int WORD_W  = 16;
  localparam int NUM_WORDS = 3;
  localparam int PTR_W   = 2;

  localparam logic [7:0] MODE_CLEAR  = 8'hF4;
  localparam logic [7:0] MODE_CALC   = 8'hB4;
  localparam logic [7:0] MODE_RESULT = 8'hD4;

  typedef struct packed {
    logic             clearAll;
    logic             accumEn;
    logic             grpSel;
    logic [IDX_W-1:0] lineIdx;
    logic             resultOn;
    logic [PTR_W-1:0] wordSel;
  } ecc_stb_t;

  // Mask of data bit positions whose position bit 'lvl' equals 'odd'.
  function automatic logic [DATA_W-1:0] colMask(int lvl, bit odd);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) m[b] = (((b >> lvl) & 1) == int'(odd));
    return m;
  endfunction
endpackage

// File: rtl/sector_ecc_ctrl.sv
module sector_ecc_ctrl
  import sector_ecc_pkg::*;
#(
  parameter int GROUP_IDX_W = IDX_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] modeCode,
  input  logic       byteValid,
  input  logic       readStrobe,
  output ecc_stb_t   stb
);
  localparam int CNT_W = GROUP_IDX_W + 2;
  localparam logic [PTR_W-1:0] LAST_WORD = PTR_W'(NUM_WORDS - 1);

  logic [CNT_W-1:0] byteCnt;
  logic [PTR_W-1:0] wordPtr;
  logic modeClear, modeCalc, modeResult, sectorFull, takeByte;

  assign modeClear  = (modeCode == MODE_CLEAR);
  assign modeCalc   = (modeCode == MODE_CALC);
  assign modeResult = (modeCode == MODE_RESULT);
  assign sectorFull = byteCnt[CNT_W-1];
  assign takeByte   = modeCalc && byteValid && !sectorFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          byteCnt <= '0;
    else if (modeClear) byteCnt <= '0;
    else if (takeByte)  byteCnt <= byteCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wordPtr <= '0;
    else if (!modeResult) wordPtr <= '0;
    else if (readStrobe)  wordPtr <= (wordPtr == LAST_WORD) ? '0 : wordPtr + 1'b1;
  end

  always_comb begin
    stb.clearAll = modeClear;
    stb.accumEn  = takeByte;
    stb.grpSel   = byteCnt[GROUP_IDX_W];
    stb.lineIdx  = byteCnt[GROUP_IDX_W-1:0];
    stb.resultOn = modeResult;
    stb.wordSel  = wordPtr;
  end
endmodule

// File: rtl/sector_ecc_group.sv
module sector_ecc_group
  import sector_ecc_pkg::*;
#(
  parameter int GW = DATA_W,
  parameter int GI = IDX_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clear,
  input  logic            en,
  input  logic [GI-1:0]   idx,
  input  logic [GW-1:0]   data,
  output logic [2*GI-1:0] lineOut,
  output logic [7:0]      colOut
);
  localparam int LVLS = $clog2(GW);
  localparam int CP_W = 2 * LVLS;

  logic [2*GI-1:0] lineAcc, lineNext;
  logic [CP_W-1:0] colAcc, colNext;
  logic bytePar;

  assign bytePar = ^data;

  genvar k;
  generate
    for (k = 0; k < GI; k++) begin : g_line
      assign lineNext[2*k]   = lineAcc[2*k]   ^ (bytePar & ~idx[k]);
      assign lineNext[2*k+1] = lineAcc[2*k+1] ^ (bytePar &  idx[k]);
    end
    for (k = 0; k < LVLS; k++) begin : g_col
      assign colNext[2*k]   = colAcc[2*k]   ^ (^(data & colMask(k, 1'b0)));
      assign colNext[2*k+1] = colAcc[2*k+1] ^ (^(data & colMask(k, 1'b1)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineAcc <= '0;
      colAcc  <= '0;
    end else if (clear) begin
      lineAcc <= '0;
      colAcc  <= '0;
    end else if (en) begin
      lineAcc <= lineNext;
      colAcc  <= colNext;
    end
  end

  assign lineOut = ~lineAcc;
  assign colOut  = {~colAcc, {(8-CP_W){1'b1}}};
endmodule

// File: rtl/sector_ecc_dpath.sv
module sector_ecc_dpath
  import sector_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ecc_stb_t          stb,
  input  logic [DATA_W-1:0] byteData,
  output logic [WORD_W-1:0] readData
);
  localparam int NGRP = 2;

  logic [2*IDX_W-1:0] lineP [NGRP];
  logic [7:0]         colP  [NGRP];

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      logic grpEn;
      assign grpEn = stb.accumEn && (stb.grpSel == 1'(g));
      sector_ecc_group #(.GW(DATA_W), .GI(IDX_W)) grp_i (
        .clk(clk), .rstN(rstN), .clear(stb.clearAll), .en(grpEn),
        .idx(stb.lineIdx), .data(byteData),
        .lineOut(lineP[g]), .colOut(colP[g])
      );
    end
  endgenerate

  always_comb begin
    readData = '0;
    if (stb.resultOn) begin
      case (stb.wordSel)
        2'd0:    readData = {lineP[0][15:8], lineP[0][7:0]};
        2'd1:    readData = {lineP[1][7:0], colP[0]};
        2'd2:    readData = {colP[1], lineP[1][15:8]};
        default: readData = '0;
      endcase
    end
  end
endmodule

// File: rtl/sector_ecc_gen.sv
module sector_ecc_gen
  import sector_ecc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  modeCode,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        readStrobe,
  output logic [15:0] readData
);
  ecc_stb_t stb;

  sector_ecc_ctrl #(.GROUP_IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeCode(modeCode),
    .byteValid(byteValid), .readStrobe(readStrobe), .stb(stb)
  );

  sector_ecc_dpath dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .byteData(byteData), .readData(readData)
  );
endmodule

// File: rtl/sector_ecc_gen_chk.sv
module sector_ecc_gen_chk
  import sector_ecc_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  modeCode,
  input logic        readStrobe,
  input logic [15:0] readData,
  input ecc_stb_t    stb
);
  // R8: port reads zero outside readout mode
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode != MODE_RESULT) |-> (readData == 16'h0000));

  // R1: readout right after a clear shows all-ones parity
  p_fresh_ones_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == MODE_RESULT && $past(modeCode) == MODE_CLEAR) |-> (readData == 16'hFFFF));

  // R2: parity never accumulates outside the accumulate code
  p_no_accum_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode != MODE_CALC) |-> !stb.accumEn);

  // R9: without a read strobe the readout word holds
  p_hold_word_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == MODE_RESULT && $past(modeCode) == MODE_RESULT && !$past(readStrobe))
      |-> $stable(readData));

  // R2: clear, accumulate and readout strobes are mutually exclusive
  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.clearAll, stb.accumEn, stb.resultOn}));
endmodule

bind sector_ecc_gen sector_ecc_gen_chk chk_i (
  .clk(clk), .rstN(rstN), .modeCode(modeCode), .readStrobe(readStrobe),
  .readData(readData), .stb(stb)
);

// File: tb/sector_ecc_gen_tb_top.sv
module sector_ecc_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  modeCode = 8'h00;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic        readStrobe = 1'b0;
  logic [15:0] readData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam int NROWS = 7;
  // Stimulus table: pattern kind, seed, byte count, flags
  // flags: bit0 read strobe during accumulation, bit1 bytes during readout + re-entry,
  //        bit2 read strobes under the clear code
  localparam int ROW_KIND [NROWS] = '{0,   1,   2,   2,   3,   3,   3};
  localparam int ROW_SEED [NROWS] = '{0,  90,  37, 300,   7,  99,  11};
  localparam int ROW_CNT  [NROWS] = '{512, 512, 512, 512, 300, 600, 512};
  localparam int ROW_FLAG [NROWS] = '{0,   0,   0,   0,   2,   0,   5};

  logic [7:0] secMem [0:599];

  always #5 clk = ~clk;

  sector_ecc_gen dut_i (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .byteValid(byteValid),
    .byteData(byteData), .readStrobe(readStrobe), .readData(readData)
  );

  function automatic logic [7:0] genByte(int kind, int seed, int idx);
    case (kind)
      0:       return 8'hFF;
      1:       return 8'(idx) ^ 8'(seed);
      2:       return (idx == seed) ? 8'h10 : 8'h00;
      default: return 8'((idx * 37 + seed) ^ (idx >> 3));
    endcase
  endfunction

  // Reference: returns {word2, word1, word0} for the first n bytes of secMem
  function automatic logic [47:0] model(int n);
    logic [15:0] lp [2];
    logic [5:0]  cp [2];
    logic [7:0]  b, colB [2], lpL [2], lpH [2];
    logic p;
    int used;
    used = (n > 512) ? 512 : n;
    for (int h = 0; h < 2; h++) begin lp[h] = '0; cp[h] = '0; end
    for (int j = 0; j < used; j++) begin
      int h, i;
      h = j / 256; i = j % 256;
      b = secMem[j];
      p = ^b;
      for (int k = 0; k < 8; k++)
        if (((i >> k) & 1) == 1) lp[h][2*k+1] ^= p; else lp[h][2*k] ^= p;
      cp[h][0] ^= b[0] ^ b[2] ^ b[4] ^ b[6];
      cp[h][1] ^= b[1] ^ b[3] ^ b[5] ^ b[7];
      cp[h][2] ^= b[0] ^ b[1] ^ b[4] ^ b[5];
      cp[h][3] ^= b[2] ^ b[3] ^ b[6] ^ b[7];
      cp[h][4] ^= b[0] ^ b[1] ^ b[2] ^ b[3];
      cp[h][5] ^= b[4] ^ b[5] ^ b[6] ^ b[7];
    end
    for (int h = 0; h < 2; h++) begin
      lpL[h] = ~lp[h][7:0];
      lpH[h] = ~lp[h][15:8];
      colB[h] = {~cp[h], 2'b11};
    end
    return {colB[1], lpH[1], lpL[1], colB[0], lpH[0], lpL[0]};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setMode(logic [7:0] m, int cycles, bit rd);
    @(negedge clk);
    modeCode = m; readStrobe = rd;
    for (int c = 1; c < cycles; c++) @(negedge clk);
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic feed(int n, bit rdAlso);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      byteValid = 1'b1; byteData = secMem[j]; readStrobe = rdAlso;
    end
    @(negedge clk);
    byteValid = 1'b0; readStrobe = 1'b0;
  endtask

  task automatic readWord(string req, logic [15:0] exp);
    check(req, readData, exp);
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    logic [47:0] exp;
    string req;
    repeat (3) @(negedge clk);
    check("R10 reset idle", readData, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);

    // R1: clear then readout gives all ones, three words
    setMode(MODE_CLEAR_C(), 2, 1'b0);
    modeCode = 8'hD4;
    @(negedge clk);
    for (int w = 0; w < 3; w++) readWord("R1 cleared", 16'hFFFF);

    // Table walk
    for (int r = 0; r < NROWS; r++) begin
      for (int j = 0; j < 600; j++) secMem[j] = genByte(ROW_KIND[r], ROW_SEED[r], j);
      exp = model(ROW_CNT[r]);
      case (r)
        0: req = "R5 erased";
        1: req = "R4 column";
        2: req = "R3 line";
        3: req = "R7 order";
        4: req = "R6 partial";
        5: req = "R6 overflow";
        default: req = "R9 strobes";
      endcase
      setMode(8'hF4, 2, ROW_FLAG[r][2]);
      modeCode = 8'hB4;
      feed(ROW_CNT[r], ROW_FLAG[r][0]);
      setMode(8'h00, 1, ROW_FLAG[r][0]);
      modeCode = 8'hD4;
      @(negedge clk);
      readWord(req, exp[15:0]);
      readWord(req, exp[31:16]);
      readWord(req, exp[47:32]);
      readWord("R8 wrap", exp[15:0]);
      if (ROW_FLAG[r][1]) begin
        // R2: bytes under readout and idle codes are ignored; R8 position restarts
        readStrobe = 1'b1;
        @(negedge clk);
        readStrobe = 1'b0;
        for (int j = 0; j < 5; j++) begin
          byteValid = 1'b1; byteData = 8'h5B + 8'(j);
          @(negedge clk);
        end
        modeCode = 8'h00;
        for (int j = 0; j < 3; j++) @(negedge clk);
        byteValid = 1'b0;
        check("R8 idle zero", readData, 16'h0000);
        modeCode = 8'hD4;
        @(negedge clk);
        readWord("R2 ignored", exp[15:0]);
        readWord("R2 ignored", exp[31:16]);
        readWord("R2 ignored", exp[47:32]);
      end
    end

    // R9: read strobes under idle code do not move the readout position
    modeCode = 8'h00;
    readStrobe = 1'b1;
    repeat (2) @(negedge clk);
    readStrobe = 1'b0;
    modeCode = 8'hD4;
    @(negedge clk);
    check("R9 idle read", readData, exp[15:0]);

    // R10: reset in the middle of a sector behaves like a clear
    modeCode = 8'hB4;
    for (int j = 0; j < 600; j++) secMem[j] = genByte(3, 5, j);
    feed(40, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    modeCode = 8'hD4;
    @(negedge clk);
    for (int w = 0; w < 3; w++) readWord("R10 midreset", 16'hFFFF);

    finish();
  end

  function automatic logic [7:0] MODE_CLEAR_C();
    return 8'hF4;
  endfunction
endmodule